// File: doc/BRIEF.md
# Register Port Control Decoder

This block turns the packed register-access field of one instruction in a clause-based shader instruction set into concrete register-port actions. The field holds four 6-bit register numbers (`fld_a`, `fld_b`, `fld_c`, `fld_d`) and a 4-bit control code. From these the decoder works out three things:

- the register numbers and enables of the two read ports;
- a 5-bit selector into a slot-behaviour table;
- the resulting write destinations of the two execution units, FMA and ADD, including half-word masks.

Two register numbers share one ordered encoding. If the first field is larger than the second, both numbers are stored mirrored (63 minus the value). The table selector is rewritten from the control code according to two things: the instruction's position at a clause edge, and whether the two slot register fields match.

The decoder is combinational. A parameter can add one output register stage. The slot-behaviour table is a parameter, and an all-zero table entry is reserved and flagged.

The clause edge input is set for the first instruction of a clause. It is also set when the write destinations of the last instruction are resolved, because those come from the first instruction's field.

Top module: `regport_ctrl_decoder`

## Requirements
- R1: When `ctl` is 0, read port 0 gives `fld_a` with bit 5 forced high if `fld_b[0]` is 1 (bitwise OR), and read port 1 gives register 0.
- R2: When `ctl` is 0, `rd0_en` equals the inverse of `fld_b[1]` and `rd1_en` is 0. The base selector is `fld_b[5:2]`.
- R3: When `ctl` is nonzero, both enables are 1 and the base selector is `ctl`.
  - If `fld_a <= fld_b`, the ports give `fld_a` and `fld_b`.
  - Otherwise they give `63-fld_a` and `63-fld_b`.
  - In both cases port 0's number never exceeds port 1's.
- R4: When `head` is 1, the selector keeps base bits 2:0, has bit 3 cleared, and has base bit 3 moved to bit 4.
- R5: When `head` is 0, the selector is the base plus 16 if `fld_c == fld_d`, and the base otherwise. Head positioning takes priority over the equality rule.
- R6: Table entry `k` sits at bits `[7k+6:7k]` of `SLOT_TABLE`.
  - Bits 2:0 are the slot-2 operation and bits 5:3 the slot-3 operation.
  - Bit 6 set means the FMA unit owns slot 3.
  - Operation codes: 0 idle, 1 read, 2 write full, 3 write low half, 4 write high half. Codes 5 to 7 act as idle.
- R7: FMA write target:
  - If slot 2 holds a write code (2 to 4), FMA writes `fld_c`.
  - Otherwise, if slot 3 holds a write code and the FMA unit owns slot 3, FMA writes `fld_d`.
  - Otherwise FMA does not write, and its register and mask outputs are 0.
- R8: ADD writes `fld_d` exactly when slot 3 holds a write code and the ADD unit owns slot 3. Otherwise its register and mask outputs are 0.
- R9: Write masks are 2'b11 for write full, 2'b01 for write low half, and 2'b10 for write high half.
- R10: `reserved_hit` is 1 exactly when the selected table entry is all zeros. Such an entry produces no write.
- R11: With `REG_OUT`=1, every output shows the decode of the inputs present at the previous rising clock edge, and all outputs are 0 while `rst_n` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output stage |
| rst_n | input | 1 | Active-low reset of the output stage |
| fld_a | input | 6 | First packed read register field |
| fld_b | input | 6 | Second packed read register field |
| fld_c | input | 6 | Slot-2 register field |
| fld_d | input | 6 | Slot-3 register field |
| ctl | input | 4 | Control code |
| head | input | 1 | Instruction sits at the clause edge |
| rd0_reg | output | 6 | Read port 0 register number |
| rd0_en | output | 1 | Read port 0 enable |
| rd1_reg | output | 6 | Read port 1 register number |
| rd1_en | output | 1 | Read port 1 enable |
| sel_idx | output | 5 | Rewritten slot-table selector |
| slot2_op | output | 3 | Slot-2 operation code |
| slot3_op | output | 3 | Slot-3 operation code |
| slot3_by_fma | output | 1 | FMA unit owns slot 3 |
| fma_we | output | 1 | FMA result is written to a register |
| fma_dst | output | 6 | FMA destination register |
| fma_mask | output | 2 | FMA half-word mask |
| add_we | output | 1 | ADD result is written to a register |
| add_dst | output | 6 | ADD destination register |
| add_mask | output | 2 | ADD half-word mask |
| reserved_hit | output | 1 | Selected table entry is reserved |

## Verification
Two pairs of rules can apply in the same cycle.

The clause-edge rewrite and the equal-slot increment both apply when `head` is 1 and `fld_c` equals `fld_d`. The sweep drives that combination for every control code and judges that the selector carries no +16.

The mirrored port decode and the reserved-entry flag coincide when a nonzero control code, with `fld_a > fld_b`, selects one of the two all-zero entries in the bench's table. The sweep checks that the port numbers are still mirrored while no write is issued.

// File: rtl/regport_pkg.sv
package regport_pkg;

  localparam int REG_W   = 6;
  localparam int CTL_W   = 4;
  localparam int SEL_W   = CTL_W + 1;
  localparam int OP_W    = 3;
  localparam int ENT_W   = 2 * OP_W + 1;
  localparam int N_ENT   = 1 << SEL_W;
  localparam int TBL_W   = N_ENT * ENT_W;

  typedef enum logic [OP_W-1:0] {
    SOP_IDLE  = 3'd0,
    SOP_READ  = 3'd1,
    SOP_WFULL = 3'd2,
    SOP_WLO   = 3'd3,
    SOP_WHI   = 3'd4
  } slot_op_e;

  typedef struct packed {
    logic [REG_W-1:0] rd0_reg;
    logic             rd0_en;
    logic [REG_W-1:0] rd1_reg;
    logic             rd1_en;
    logic [SEL_W-1:0] sel_idx;
    logic [OP_W-1:0]  slot2_op;
    logic [OP_W-1:0]  slot3_op;
    logic             slot3_by_fma;
    logic             fma_we;
    logic [REG_W-1:0] fma_dst;
    logic [1:0]       fma_mask;
    logic             add_we;
    logic [REG_W-1:0] add_dst;
    logic [1:0]       add_mask;
    logic             reserved_hit;
  } dec_out_t;

  function automatic logic op_writes(input logic [OP_W-1:0] op);
    return (op == SOP_WFULL) || (op == SOP_WLO) || (op == SOP_WHI);
  endfunction

  function automatic logic [1:0] op_mask(input logic [OP_W-1:0] op);
    case (op)
      SOP_WFULL: return 2'b11;
      SOP_WLO:   return 2'b01;
      SOP_WHI:   return 2'b10;
      default:   return 2'b00;
    endcase
  endfunction

  // Default table: entry 0 reserved, others cycle through the operation codes.
  function automatic logic [TBL_W-1:0] default_table();
    logic [TBL_W-1:0] t;
    t = '0;
    for (int k = 1; k < N_ENT; k++) begin
      t[k*ENT_W +: ENT_W] = {k[0], 3'((k + 2) % 5), 3'((k + 1) % 5)};
    end
    return t;
  endfunction

endpackage

// File: rtl/regport_port_resolve.sv
module regport_port_resolve #(
  parameter int REG_W = 6,
  parameter int CTL_W = 4
) (
  input  logic [REG_W-1:0] fld_a,
  input  logic [REG_W-1:0] fld_b,
  input  logic [CTL_W-1:0] ctl,
  output logic [REG_W-1:0] rd0_reg,
  output logic             rd0_en,
  output logic [REG_W-1:0] rd1_reg,
  output logic             rd1_en,
  output logic             packed_mode,
  output logic             mirrored
);

  localparam logic [REG_W-1:0] TOP_REG = {REG_W{1'b1}};

  function automatic logic [REG_W-1:0] unfold(input logic [REG_W-1:0] v,
                                              input logic flip);
    return flip ? (TOP_REG - v) : v;
  endfunction

  function automatic logic [REG_W-1:0] widen_low(input logic [REG_W-1:0] a,
                                                 input logic b0);
    return a | {b0, {(REG_W-1){1'b0}}};
  endfunction

  assign packed_mode = (ctl == '0);
  assign mirrored    = !packed_mode && (fld_a > fld_b);

  always_comb begin
    if (packed_mode) begin
      rd0_reg = widen_low(fld_a, fld_b[0]);
      rd0_en  = !fld_b[1];
      rd1_reg = '0;
      rd1_en  = 1'b0;
    end else begin
      rd0_reg = unfold(fld_a, mirrored);
      rd0_en  = 1'b1;
      rd1_reg = unfold(fld_b, mirrored);
      rd1_en  = 1'b1;
    end
  end

endmodule

// File: rtl/regport_index_rewrite.sv
module regport_index_rewrite #(
  parameter int REG_W = 6,
  parameter int CTL_W = 4,
  localparam int SEL_W = CTL_W + 1
) (
  input  logic [REG_W-1:0] fld_b,
  input  logic [REG_W-1:0] fld_c,
  input  logic [REG_W-1:0] fld_d,
  input  logic [CTL_W-1:0] ctl,
  input  logic             head,
  output logic [CTL_W-1:0] base_idx,
  output logic             slot_match,
  output logic [SEL_W-1:0] sel_idx
);

  function automatic logic [SEL_W-1:0] edge_form(input logic [CTL_W-1:0] b);
    return {b[CTL_W-1], 1'b0, b[CTL_W-2:0]};
  endfunction

  function automatic logic [SEL_W-1:0] body_form(input logic [CTL_W-1:0] b,
                                                 input logic bump);
    return {bump, b};
  endfunction

  assign base_idx   = (ctl == '0) ? fld_b[2 +: CTL_W] : ctl;
  assign slot_match = (fld_c == fld_d);
  assign sel_idx    = head ? edge_form(base_idx) : body_form(base_idx, slot_match);

endmodule

// File: rtl/regport_slot_lookup.sv
module regport_slot_lookup
  import regport_pkg::*;
#(
  parameter int REG_W = 6,
  parameter int SEL_W = 5,
  localparam int N_E  = 1 << SEL_W,
  localparam int E_W  = 2 * OP_W + 1,
  parameter logic [N_E*E_W-1:0] SLOT_TABLE = '0
) (
  input  logic [SEL_W-1:0] sel_idx,
  input  logic [REG_W-1:0] fld_c,
  input  logic [REG_W-1:0] fld_d,
  output logic [OP_W-1:0]  slot2_op,
  output logic [OP_W-1:0]  slot3_op,
  output logic             slot3_by_fma,
  output logic             fma_we,
  output logic [REG_W-1:0] fma_dst,
  output logic [1:0]       fma_mask,
  output logic             add_we,
  output logic [REG_W-1:0] add_dst,
  output logic [1:0]       add_mask,
  output logic             reserved_hit
);

  logic [E_W-1:0] entries [N_E];
  logic [E_W-1:0] pick;

  for (genvar k = 0; k < N_E; k++) begin : g_ent
    assign entries[k] = SLOT_TABLE[k*E_W +: E_W];
  end

  assign pick         = entries[sel_idx];
  assign slot2_op     = pick[OP_W-1:0];
  assign slot3_op     = pick[2*OP_W-1:OP_W];
  assign slot3_by_fma = pick[E_W-1];
  assign reserved_hit = (pick == '0);

  logic s2_wr, s3_wr;
  assign s2_wr = op_writes(slot2_op);
  assign s3_wr = op_writes(slot3_op);

  always_comb begin
    fma_we   = 1'b0;
    fma_dst  = '0;
    fma_mask = 2'b00;
    if (s2_wr) begin
      fma_we   = 1'b1;
      fma_dst  = fld_c;
      fma_mask = op_mask(slot2_op);
    end else if (s3_wr && slot3_by_fma) begin
      fma_we   = 1'b1;
      fma_dst  = fld_d;
      fma_mask = op_mask(slot3_op);
    end
  end

  always_comb begin
    add_we   = s3_wr && !slot3_by_fma;
    add_dst  = add_we ? fld_d : '0;
    add_mask = add_we ? op_mask(slot3_op) : 2'b00;
  end

endmodule

// File: rtl/regport_ctrl_decoder.sv
module regport_ctrl_decoder
  import regport_pkg::*;
#(
  parameter bit REG_OUT = 1'b0,
  parameter logic [TBL_W-1:0] SLOT_TABLE = default_table()
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [REG_W-1:0] fld_a,
  input  logic [REG_W-1:0] fld_b,
  input  logic [REG_W-1:0] fld_c,
  input  logic [REG_W-1:0] fld_d,
  input  logic [CTL_W-1:0] ctl,
  input  logic             head,
  output logic [REG_W-1:0] rd0_reg,
  output logic             rd0_en,
  output logic [REG_W-1:0] rd1_reg,
  output logic             rd1_en,
  output logic [SEL_W-1:0] sel_idx,
  output logic [OP_W-1:0]  slot2_op,
  output logic [OP_W-1:0]  slot3_op,
  output logic             slot3_by_fma,
  output logic             fma_we,
  output logic [REG_W-1:0] fma_dst,
  output logic [1:0]       fma_mask,
  output logic             add_we,
  output logic [REG_W-1:0] add_dst,
  output logic [1:0]       add_mask,
  output logic             reserved_hit
);

  dec_out_t         comb_o, out_q;
  logic             packed_mode, mirrored, slot_match;
  logic [CTL_W-1:0] base_idx;

  regport_port_resolve #(.REG_W(REG_W), .CTL_W(CTL_W)) port_i (
    .fld_a(fld_a), .fld_b(fld_b), .ctl(ctl),
    .rd0_reg(comb_o.rd0_reg), .rd0_en(comb_o.rd0_en),
    .rd1_reg(comb_o.rd1_reg), .rd1_en(comb_o.rd1_en),
    .packed_mode(packed_mode), .mirrored(mirrored)
  );

  regport_index_rewrite #(.REG_W(REG_W), .CTL_W(CTL_W)) idx_i (
    .fld_b(fld_b), .fld_c(fld_c), .fld_d(fld_d), .ctl(ctl), .head(head),
    .base_idx(base_idx), .slot_match(slot_match), .sel_idx(comb_o.sel_idx)
  );

  regport_slot_lookup #(.REG_W(REG_W), .SEL_W(SEL_W), .SLOT_TABLE(SLOT_TABLE)) lut_i (
    .sel_idx(comb_o.sel_idx), .fld_c(fld_c), .fld_d(fld_d),
    .slot2_op(comb_o.slot2_op), .slot3_op(comb_o.slot3_op),
    .slot3_by_fma(comb_o.slot3_by_fma),
    .fma_we(comb_o.fma_we), .fma_dst(comb_o.fma_dst), .fma_mask(comb_o.fma_mask),
    .add_we(comb_o.add_we), .add_dst(comb_o.add_dst), .add_mask(comb_o.add_mask),
    .reserved_hit(comb_o.reserved_hit)
  );

  if (REG_OUT) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) out_q <= '0;
      else        out_q <= comb_o;
    end
  end else begin : g_comb
    assign out_q = comb_o;
  end

  assign rd0_reg      = out_q.rd0_reg;
  assign rd0_en       = out_q.rd0_en;
  assign rd1_reg      = out_q.rd1_reg;
  assign rd1_en       = out_q.rd1_en;
  assign sel_idx      = out_q.sel_idx;
  assign slot2_op     = out_q.slot2_op;
  assign slot3_op     = out_q.slot3_op;
  assign slot3_by_fma = out_q.slot3_by_fma;
  assign fma_we       = out_q.fma_we;
  assign fma_dst      = out_q.fma_dst;
  assign fma_mask     = out_q.fma_mask;
  assign add_we       = out_q.add_we;
  assign add_dst      = out_q.add_dst;
  assign add_mask     = out_q.add_mask;
  assign reserved_hit = out_q.reserved_hit;

  // Port decode keeps ordering on the unfolded numbers.
  assert_port_order_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !packed_mode |-> (comb_o.rd0_reg <= comb_o.rd1_reg));

  assert_port1_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    packed_mode |-> !comb_o.rd1_en);

  assert_edge_bit3_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    head |-> !comb_o.sel_idx[CTL_W-1]);

  assert_no_bump_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!head && !slot_match) |-> (comb_o.sel_idx[CTL_W] == 1'b0));

  assert_single_owner_R8: assert property (@(posedge clk) disable iff (!rst_n)
    comb_o.add_we |-> !comb_o.slot3_by_fma);

  assert_reserved_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    comb_o.reserved_hit |-> (!comb_o.fma_we && !comb_o.add_we));

  assert_mask_with_we_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (comb_o.fma_we == (comb_o.fma_mask != 2'b00)) && (comb_o.add_we == (comb_o.add_mask != 2'b00)));

  if (REG_OUT) begin : g_reg_chk
    assert_stage_delay_R11: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |=> (out_q == $past(comb_o)));
  end

  logic unused_base;
  assign unused_base = ^{base_idx, mirrored};

endmodule

// File: tb/regport_ctrl_decoder_tb_top.sv
module regport_ctrl_decoder_tb_top;

  localparam int NE = 32;

  function automatic logic [NE*7-1:0] mk_tbl();
    logic [NE*7-1:0] r;
    r = '0;
    for (int i = 0; i < NE; i++) begin
      logic [6:0] e;
      e = {i[1], 3'((i * 7 + 2) % 5), 3'((i * 3 + 1) % 5)};
      if (i == 0 || i == 21) e = '0;
      r[i*7 +: 7] = e;
    end
    return r;
  endfunction

  localparam logic [NE*7-1:0] TB_TBL = mk_tbl();

  logic clk = 1'b0, rst_n = 1'b0;
  always #2ns clk = ~clk;

  logic [5:0] fa = '0, fb = '0, fc = '0, fd = '0;
  logic [3:0] ct = '0;
  logic       hd = 1'b0;
  logic [5:0] r0, r1, fdst, adst;
  logic       e0, e1, s3f, fwe, awe, rsv;
  logic [4:0] sidx;
  logic [2:0] s2o, s3o;
  logic [1:0] fm, am;

  regport_ctrl_decoder #(.REG_OUT(1'b1), .SLOT_TABLE(TB_TBL)) dut_i (
    .clk(clk), .rst_n(rst_n), .fld_a(fa), .fld_b(fb), .fld_c(fc), .fld_d(fd),
    .ctl(ct), .head(hd), .rd0_reg(r0), .rd0_en(e0), .rd1_reg(r1), .rd1_en(e1),
    .sel_idx(sidx), .slot2_op(s2o), .slot3_op(s3o), .slot3_by_fma(s3f),
    .fma_we(fwe), .fma_dst(fdst), .fma_mask(fm), .add_we(awe), .add_dst(adst),
    .add_mask(am), .reserved_hit(rsv)
  );

  int n_chk = 0, n_err = 0;

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual=%0d expected=%0d (a=%0d b=%0d c=%0d d=%0d ctl=%0d head=%0b)",
               req, act, exp, fa, fb, fc, fd, ct, hd);
    end
  endtask

  function automatic bit wr(input logic [2:0] op);
    return op inside {3'd2, 3'd3, 3'd4};
  endfunction

  function automatic int msk(input logic [2:0] op);
    case (op) 3'd2: return 3; 3'd3: return 1; 3'd4: return 2; default: return 0; endcase
  endfunction

  task automatic judge();
    int xp0, xp1, xe0, xe1, base, xi, xfw, xfd, xfm, xaw, xad, xam;
    logic [6:0] ent;
    logic [2:0] o2, o3;
    if (ct == 0) begin
      // R1 and R2: packed form
      xp0 = fa + ((fb[0] && !fa[5]) ? 32 : 0);
      xp1 = 0; xe0 = !fb[1]; xe1 = 0; base = fb / 4;
    end else begin
      // R3: ordered pair, mirrored via complement
      if (fa <= fb) begin xp0 = fa; xp1 = fb; end
      else begin xp0 = 6'(~fa); xp1 = 6'(~fb); end
      xe0 = 1; xe1 = 1; base = ct;
    end
    if (hd) xi = (base % 8) + ((base >= 8) ? 16 : 0);        // R4
    else    xi = base + ((fc == fd) ? 16 : 0);               // R5
    ent = TB_TBL[xi*7 +: 7];
    o2 = ent[2:0]; o3 = ent[5:3];
    xfw = 0; xfd = 0; xfm = 0; xaw = 0; xad = 0; xam = 0;
    if (wr(o2)) begin xfw = 1; xfd = fc; xfm = msk(o2); end
    else if (wr(o3) && ent[6]) begin xfw = 1; xfd = fd; xfm = msk(o3); end
    if (wr(o3) && !ent[6]) begin xaw = 1; xad = fd; xam = msk(o3); end
    chk("R1_R3 port0", r0, xp0);
    chk("R1_R3 port1", r1, xp1);
    chk("R2 enables", {e0, e1}, xe0 * 2 + xe1);
    chk("R4_R5 selector", sidx, xi);
    chk("R6 ops", {s3f, s3o, s2o}, ent);
    chk("R7 fma dest", {fwe, fdst}, xfw * 64 + xfd);
    chk("R8 add dest", {awe, adst}, xaw * 64 + xad);
    chk("R9 masks", {fm, am}, xfm * 4 + xam);
    chk("R10 reserved", rsv, (ent == 0) ? 1 : 0);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin : stim
    int pick[9];
    pick = '{0, 1, 2, 5, 31, 32, 33, 62, 63};
    fa = 6'd40; fb = 6'd7; ct = 4'd3; hd = 1'b1;
    repeat (3) @(negedge clk);
    chk("R11 reset outputs", {r0, e0, r1, e1, sidx, fwe, awe, rsv}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    for (int c = 0; c < 16; c++)
      for (int i = 0; i < 9; i++)
        for (int j = 0; j < 9; j++)
          for (int m = 0; m < 4; m++) begin
            fa = 6'(pick[i]); fb = 6'(pick[j]); ct = 4'(c);
            hd = m[0];
            fc = 6'(pick[i] + pick[j] * 3);
            fd = m[1] ? fc : (fc ^ 6'h15);
            @(negedge clk);
            judge();   // R11: registered one edge after the drive
          end
    // R11: outputs hold the previous decode until the next edge
    fa = 6'd9; fb = 6'd4; ct = 4'd1; hd = 1'b0; fc = 6'd2; fd = 6'd2;
    @(posedge clk); #1ns;
    chk("R11 latency", r0, 6'(~6'd9));
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule